// File: doc/BRIEF.md
# Quadrature Quarter-Wave Sine/Cosine Generator

This block turns a phase word from a phase accumulator into a pair of signed samples, sine and cosine, produced together on every clock. Only the upper phase bits are used: the lowest bits are dropped before a table address is formed. The two top kept bits name the quadrant, and the remaining kept bits index a table that holds one quarter of a sine period.

A single quarter-period table serves both outputs. The sine path mirrors the address inside the quadrant and negates the fetched amplitude as the quadrant requires. The cosine path first advances the quadrant by one and then applies the same decode. The table is computed during elaboration from a series expansion, so no external data is needed. Each result appears exactly two clocks after its phase word is presented.

Top module: `qsc_sincos_gen`

## Requirements
- R1: While `rst` is high at a rising edge, both outputs are 0 after that edge. This holds for a reset at power-up and for a reset that arrives in the middle of a run.
- R2: The outputs for a phase word sampled at rising edge n appear after rising edge n+2. A new phase may be presented on every clock.
- R3: Phase bits [3:0] (with default widths) have no effect on either output.
- R4: The table entry is T[k] = round(511 * sin(pi/2 * (k + 0.5) / 256)) for k in 0..255. With quadrant bits [13:12] = 00 and address a = phase[11:4], the sine output equals T[a].
- R5: When phase bit 12 is 1, the sine path reads T[255 - a], which is the bitwise inverse of a.
- R6: When phase bit 13 is 1, the sine output is the negated table value. Otherwise it is the positive table value.
- R7: The cosine output equals the sine output that would result after adding 01 to bits [13:12] modulo 4, with the address bits unchanged.
- R8: Both outputs stay within the symmetric range -511..+511. Both extremes are reached, and -512 never occurs.
- R9: Where the sine magnitude is at its minimum (T[0]), the cosine magnitude is at its maximum (T[255] = 511).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| phase_i | input | 14 | Phase word; bits [13:12] quadrant, [11:4] table address, [3:0] discarded |
| sin_o | output | 10 | Sine sample, two's complement |
| cos_o | output | 10 | Cosine sample, two's complement |

## Verification
The case that is hardest to reach is a quadrant wrap while phases are streaming. The cosine quadrant rolls from 11 back to 00 at the same time that the sine mirror flag flips. An error in the two-cycle alignment of the sign flag with the table read only shows up when consecutive words differ in quadrant. The stimulus therefore streams all 1024 kept phase values back to back, one per clock, with varying discarded bits. Each output pair is compared against the phase that was presented two clocks earlier, which also exercises every quadrant boundary and both amplitude extremes.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

    localparam int unsigned DEF_PHASE_W = 14;
    localparam int unsigned DEF_ADDR_W  = 8;
    localparam int unsigned DEF_AMP_W   = 10;

    // Quadrant advance applied to the cosine path.
    localparam logic [1:0] COS_QUAD_SHIFT = 2'b01;
    localparam logic [1:0] SIN_QUAD_SHIFT = 2'b00;

    typedef enum logic [1:0] {
        QUAD_RISE_POS = 2'd0,
        QUAD_FALL_POS = 2'd1,
        QUAD_RISE_NEG = 2'd2,
        QUAD_FALL_NEG = 2'd3
    } quadrant_e;

    typedef struct packed {
        logic mirror;   // invert address inside the quadrant
        logic negate;   // negate the fetched amplitude
    } quad_ctl_t;

    function automatic quad_ctl_t decode_quadrant(quadrant_e q);
        quad_ctl_t c;
        c.mirror = (q == QUAD_FALL_POS) || (q == QUAD_FALL_NEG);
        c.negate = (q == QUAD_RISE_NEG) || (q == QUAD_FALL_NEG);
        return c;
    endfunction

    // Quarter-period sample at the centre of cell k, scaled to amp_max.
    function automatic int quarter_sine(int k, int depth, int amp_max);
        real x;
        real term;
        real acc;
        x    = 1.5707963267948966 * (real'(k) + 0.5) / real'(depth);
        term = x;
        acc  = x;
        for (int n = 1; n < 11; n++) begin
            term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
            acc  = acc + term;
        end
        return $rtoi(acc * real'(amp_max) + 0.5);
    endfunction

endpackage

// File: rtl/qsc_quadrant_decode.sv
module qsc_quadrant_decode
    import qsc_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter logic [1:0]  QUAD_SHIFT = SIN_QUAD_SHIFT
) (
    input  logic [ADDR_W+1:0] kept_phase_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              negate_o
);

    quadrant_e         quad;
    quad_ctl_t         ctl;
    logic [ADDR_W-1:0] fine;

    always_comb begin
        quad     = quadrant_e'(kept_phase_i[ADDR_W+1:ADDR_W] + QUAD_SHIFT);
        fine     = kept_phase_i[ADDR_W-1:0];
        ctl      = decode_quadrant(quad);
        addr_o   = ctl.mirror ? ~fine : fine;
        negate_o = ctl.negate;
    end

endmodule

// File: rtl/qsc_quarter_rom.sv
module qsc_quarter_rom
    import qsc_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned MAG_W  = DEF_AMP_W - 1,
    parameter int unsigned NPORT  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0][ADDR_W-1:0]  addr_i,
    output logic [NPORT-1:0][MAG_W-1:0]   mag_o
);

    localparam int unsigned DEPTH   = 1 << ADDR_W;
    localparam int unsigned AMP_MAX = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] table_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int ENTRY = quarter_sine(k, DEPTH, AMP_MAX);
        assign table_q[k] = MAG_W'(ENTRY);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) mag_o[p] <= '0;
            else     mag_o[p] <= table_q[addr_i[p]];
        end
    end

    // The quarter table never yields zero at a cell centre.
    AST_ENTRY_NONZERO: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (mag_o[0] != '0)) else $error("zero entry"); // R6

endmodule

// File: rtl/qsc_sign_stage.sv
module qsc_sign_stage #(
    parameter int unsigned AMP_W = qsc_pkg::DEF_AMP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    negate_i,
    input  logic [AMP_W-2:0]        mag_i,
    output logic signed [AMP_W-1:0] sample_o
);

    logic signed [AMP_W-1:0] pos;

    always_comb pos = signed'({1'b0, mag_i});

    always_ff @(posedge clk) begin
        if (rst) sample_o <= '0;
        else     sample_o <= negate_i ? -pos : pos;
    end

    AST_SYMMETRIC_RANGE: assert property (@(posedge clk) disable iff (rst)
        sample_o != {1'b1, {(AMP_W-1){1'b0}}}) else $error("asymmetric value"); // R8

endmodule

// File: rtl/qsc_sincos_gen.sv
module qsc_sincos_gen
    import qsc_pkg::*;
#(
    parameter int unsigned PHASE_W = DEF_PHASE_W,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned AMP_W   = DEF_AMP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PHASE_W-1:0]      phase_i,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);

    localparam int unsigned KEEP_W = ADDR_W + 2;
    localparam int unsigned DROP_W = PHASE_W - KEEP_W;
    localparam int unsigned MAG_W  = AMP_W - 1;
    localparam int unsigned NCH    = 2;

    logic [KEEP_W-1:0]            kept;
    logic [NCH-1:0][ADDR_W-1:0]   rd_addr;
    logic [NCH-1:0][MAG_W-1:0]    rd_mag;
    logic [NCH-1:0]               neg_d;
    logic [NCH-1:0]               neg_q;
    logic signed [AMP_W-1:0]      sample [NCH];

    assign kept = phase_i[PHASE_W-1 -: KEEP_W];

    if (DROP_W > 0) begin : g_trunc
        logic unused_trunc_bits;
        assign unused_trunc_bits = ^phase_i[DROP_W-1:0];
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam logic [1:0] SHIFT = (ch == 0) ? SIN_QUAD_SHIFT : COS_QUAD_SHIFT;

        qsc_quadrant_decode #(
            .ADDR_W    (ADDR_W),
            .QUAD_SHIFT(SHIFT)
        ) i_decode (
            .kept_phase_i(kept),
            .addr_o      (rd_addr[ch]),
            .negate_o    (neg_d[ch])
        );

        always_ff @(posedge clk) begin
            if (rst) neg_q[ch] <= 1'b0;
            else     neg_q[ch] <= neg_d[ch];
        end

        qsc_sign_stage #(
            .AMP_W(AMP_W)
        ) i_sign (
            .clk     (clk),
            .rst     (rst),
            .negate_i(neg_q[ch]),
            .mag_i   (rd_mag[ch]),
            .sample_o(sample[ch])
        );
    end

    qsc_quarter_rom #(
        .ADDR_W(ADDR_W),
        .MAG_W (MAG_W),
        .NPORT (NCH)
    ) i_rom (
        .clk   (clk),
        .rst   (rst),
        .addr_i(rd_addr),
        .mag_o (rd_mag)
    );

    assign sin_o = sample[0];
    assign cos_o = sample[1];

    // Cycles since reset, saturating; used only by the checks below.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_ADDR_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        rd_addr[1] == ~rd_addr[0]) else $error("cos address not complement"); // R7

    AST_SIN_SIGN: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (sin_o[AMP_W-1] == $past(phase_i[PHASE_W-1], 2)))
        else $error("sine sign mismatch"); // R6

    AST_COS_SIGN: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |->
        (cos_o[AMP_W-1] == (($past(phase_i[PHASE_W-1 -: 2], 2) + 2'b01) >> 1)))
        else $error("cosine sign mismatch"); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3 && $past(phase_i, 2) == $past(phase_i, 3)) |->
        ($stable(sin_o) && $stable(cos_o))) else $error("output moved"); // R2

endmodule

// File: tb/test_qsc_sincos_gen.sv
module test_qsc_sincos_gen;

    localparam int PHASE_W = 14;
    localparam int ADDR_W  = 8;
    localparam int AMP_W   = 10;
    localparam int DROP_W  = PHASE_W - ADDR_W - 2;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int AMAX    = (1 << (AMP_W - 1)) - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [PHASE_W-1:0]      phase = '0;
    logic signed [AMP_W-1:0] sin_o;
    logic signed [AMP_W-1:0] cos_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    qsc_sincos_gen i_qsc_sincos_gen (
        .clk    (clk),
        .rst    (rst),
        .phase_i(phase),
        .sin_o  (sin_o),
        .cos_o  (cos_o)
    );

    function automatic int ref_tbl(int k);
        return $rtoi(real'(AMAX) * $sin(3.14159265358979 * (real'(k) + 0.5) / real'(2 * DEPTH)) + 0.5);
    endfunction

    function automatic int ref_val(int p, int shift);
        int up;
        int q;
        int a;
        int v;
        up = p >> DROP_W;
        q  = ((up >> ADDR_W) + shift) & 3;
        a  = up & (DEPTH - 1);
        v  = ref_tbl((q & 1) ? (DEPTH - 1 - a) : a);
        return (q & 2) ? -v : v;
    endfunction

    function automatic int mk(int q, int a, int low);
        return (q << (ADDR_W + DROP_W)) | (a << DROP_W) | low;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(int p);
        @(negedge clk) phase = PHASE_W'(p);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        phase = PHASE_W'(mk(0, 200, 0));
        repeat (3) @(negedge clk);
        check("R1 reset sin", int'(sin_o), 0);
        check("R1 reset cos", int'(cos_o), 0);
        rst = 1'b0;
    endtask

    task automatic t_first_quadrant;
        int al[4] = '{0, 1, 100, 255};
        foreach (al[i]) begin
            apply(mk(0, al[i], 0));
            check("R4 sine table", int'(sin_o), ref_tbl(al[i]));
        end
    endtask

    task automatic t_mirror;
        int al[3] = '{0, 17, 255};
        foreach (al[i]) begin
            apply(mk(1, al[i], 0));
            check("R5 mirrored address", int'(sin_o), ref_tbl(DEPTH - 1 - al[i]));
        end
    endtask

    task automatic t_negate;
        apply(mk(2, 60, 0));
        check("R6 negate rise", int'(sin_o), -ref_tbl(60));
        apply(mk(3, 60, 0));
        check("R6 negate fall", int'(sin_o), -ref_tbl(DEPTH - 1 - 60));
    endtask

    task automatic t_cosine;
        for (int q = 0; q < 4; q++) begin
            apply(mk(q, 37, 0));
            check("R7 cosine quadrant shift", int'(cos_o), ref_val(mk(q, 37, 0), 1));
        end
    endtask

    task automatic t_truncation;
        int base;
        apply(mk(2, 90, 0));
        base = int'(sin_o);
        apply(mk(2, 90, 5));
        check("R3 low bits ignored sin", int'(sin_o), base);
        apply(mk(2, 90, (1 << DROP_W) - 1));
        check("R3 low bits ignored sin", int'(sin_o), base);
        check("R3 low bits ignored cos", int'(cos_o), ref_val(mk(2, 90, 0), 1));
    endtask

    task automatic t_quadrature;
        apply(mk(0, 0, 0));
        check("R9 sine minimum", int'(sin_o), ref_tbl(0));
        check("R9 cosine at peak", int'(cos_o), AMAX);
        apply(mk(1, DEPTH - 1, 0));
        check("R9 cosine at negative peak", int'(cos_o), -AMAX);
    endtask

    // Back-to-back sweep of every kept phase; output lags by two clocks.
    task automatic t_stream;
        int hist[$];
        int mn = 0;
        int mx = 0;
        int bad = 0;
        int total = 1 << (ADDR_W + 2);
        for (int i = 0; i < total + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int ps = ref_val(hist[i-2], 0);
                int pc = ref_val(hist[i-2], 1);
                if (int'(sin_o) != ps || int'(cos_o) != pc) begin
                    bad++;
                    if (bad < 4)
                        $display("FAIL R2 stream step %0d: actual %0d/%0d expected %0d/%0d",
                                 i, int'(sin_o), int'(cos_o), ps, pc);
                end
                if (int'(sin_o) < mn) mn = int'(sin_o);
                if (int'(sin_o) > mx) mx = int'(sin_o);
                if (int'(cos_o) == -(AMAX + 1)) bad++;
            end
            if (i < total) begin
                int p = (i << DROP_W) | ((i * 7) & ((1 << DROP_W) - 1));
                hist.push_back(p);
                phase = PHASE_W'(p);
            end
        end
        n_checks++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL R2 stream mismatches: actual %0d expected 0", bad);
        end
        check("R8 positive extreme", mx, AMAX);
        check("R8 negative extreme", mn, -AMAX);
    endtask

    task automatic t_midreset;
        @(negedge clk) phase = PHASE_W'(mk(0, 128, 0));
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset sin", int'(sin_o), 0);
        check("R1 mid-run reset cos", int'(cos_o), 0);
        rst = 1'b0;
        apply(mk(0, 128, 0));
        check("R1 recovery after reset", int'(sin_o), ref_tbl(128));
    endtask

    initial begin
        t_reset();
        t_first_quadrant();
        t_mirror();
        t_negate();
        t_cosine();
        t_truncation();
        t_quadrature();
        t_stream();
        t_midreset();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule